// File: doc/BRIEF.md
# BCH Syndrome Expansion Unit

This block turns the per-sector partial remainders left behind by a binary BCH checker into the complete set of 2t syndromes over GF(2^m). Software or a neighbouring engine loads up to t partial values of 16 bits each through a word-wide load port, with two values per 32-bit word. It then selects the correction capability t and the field width m and pulses `start`. Every odd syndrome S_i is built serially from the set bits of its partial value. Every even syndrome is then produced by squaring a lower syndrome that is already finished. Results are read through a combinational read port that is indexed by syndrome number.

The controller has five states.
- `ST_IDLE` waits for `start` and latches the configuration when it arrives.
- `ST_CLEAR` zeroes all syndrome storage, then always moves to `ST_ODD`.
- `ST_ODD` handles one bit position per clock. It moves to `ST_EVEN` after bit m−1 of partial value t−1.
- `ST_EVEN` writes one even syndrome per clock, in ascending order. It moves to `ST_FINISH` after S_2t.
- `ST_FINISH` raises `done` for a single cycle and always returns to `ST_IDLE`.

Field products use shift-and-reduce logic for the primitive polynomials x^13+x^4+x^3+x+1 (m = 13) and x^14+x^10+x^6+x+1 (m = 14). No lookup tables are used.

Top module: `syn_expand`

## Requirements
- R1: `cfg_t_code` and `cfg_wide` are sampled on the edge that accepts `start`. Codes 0,1,2,3,4 select t = 2,4,8,12,24, and codes 5..7 act as t = 2. `cfg_wide` = 0 selects m = 13 and `cfg_wide` = 1 selects m = 14.
- R2: Partial value k (0..t−1) is taken from load word k/2. An even k uses bits 15:0 and an odd k uses bits 31:16. Partial value k feeds syndrome S_(2k+1).
- R3: Each odd syndrome S_i equals the XOR of alpha^(i·j) over every bit j of its partial value that is set, where alpha is x in the selected field.
- R4: Bits of a partial value at positions m and above have no effect on any syndrome.
- R5: Each even syndrome S_2j equals S_j squared in the selected field, so a zero S_j gives a zero S_2j.
- R6: All syndrome storage is cleared after each accepted `start`. After a job, indices above 2t, index 0 and indices above 48 read as zero.
- R7: `busy` is high from the edge that accepts `start` until `done`. `done` is high for exactly one cycle, starting at the (t·m + t + 1)-th rising edge after the accepting edge.
- R8: Load writes are ignored while `busy` is high. A load write in the same cycle as an accepted `start` is stored and used by that job.
- R9: `start` is accepted only in `ST_IDLE`. A pulse while busy neither restarts the job nor alters its timing or results.
- R10: After reset, `busy` and `done` are low and every syndrome index reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_t_code | input | 3 | Correction capability code |
| cfg_wide | input | 1 | Field select: 0 for m = 13, 1 for m = 14 |
| wr_en | input | 1 | Load write strobe for a partial-value word |
| wr_addr | input | 4 | Load word index, 0..11 |
| wr_data | input | 32 | Two packed partial values |
| start | input | 1 | Begin an expansion job |
| rd_idx | input | 6 | Syndrome number to read |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 14 | Syndrome value at `rd_idx` |

## Verification
The load port and the start handshake can both act in the same clock cycle. The bench provokes this in two ways. First, it writes a fresh word 0 on the very edge that accepts `start`, and it judges the job's syndromes against that fresh value. Second, it drives a write of all ones together with a second `start` pulse while a job is running. That job must keep its exact latency and match the model built from the data loaded before the run. Each expected value is the received word evaluated at alpha^i by a bit-serial model in the bench.

// File: rtl/syn_pkg.sv
package syn_pkg;

    localparam int GF_M_WIDE   = 14;
    localparam int GF_M_NARROW = 13;

    // Primitive polynomials, including the leading term.
    localparam logic [14:0] POLY_WIDE   = 15'h4443;
    localparam logic [14:0] POLY_NARROW = 15'h201B;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CLEAR,
        ST_ODD,
        ST_EVEN,
        ST_FINISH
    } syn_state_e;

    // Map a capability code to t; unknown codes fall back to the smallest t.
    function automatic logic [4:0] t_of_code(input logic [2:0] code);
        case (code)
            3'd1:    return 5'd4;
            3'd2:    return 5'd8;
            3'd3:    return 5'd12;
            3'd4:    return 5'd24;
            default: return 5'd2;
        endcase
    endfunction

endpackage

// File: rtl/syn_gf_mul.sv
module syn_gf_mul
    import syn_pkg::*;
#(
    parameter int M_MAX = GF_M_WIDE
) (
    input  logic [M_MAX-1:0] a,
    input  logic [M_MAX-1:0] b,
    input  logic             wide,
    output logic [M_MAX-1:0] p
);

    logic [M_MAX:0] acc;
    logic [M_MAX:0] poly;

    // Most-significant-bit-first shift and reduce.
    always_comb begin
        poly = wide ? (M_MAX+1)'(POLY_WIDE) : (M_MAX+1)'(POLY_NARROW);
        acc  = '0;
        for (int i = M_MAX - 1; i >= 0; i--) begin
            acc = {acc[M_MAX-1:0], 1'b0};
            if (wide ? acc[M_MAX] : acc[M_MAX-1]) begin
                acc = acc ^ poly;
            end
            if (b[i]) begin
                acc = acc ^ {1'b0, a};
            end
        end
        p = acc[M_MAX-1:0];
    end

endmodule

// File: rtl/syn_part_store.sv
module syn_part_store #(
    parameter int N_WORDS = 12,
    parameter int WORD_W  = 32,
    parameter int WA_W    = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic                      lock,
    input  logic [WA_W-1:0]           wr_addr,
    input  logic [WORD_W-1:0]         wr_data,
    output logic [N_WORDS*WORD_W-1:0] words_q
);

    logic [WORD_W-1:0] mem_q [N_WORDS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int w = 0; w < N_WORDS; w++) begin
                mem_q[w] <= '0;
            end
        end else if (wr_en && !lock) begin
            for (int w = 0; w < N_WORDS; w++) begin
                if (wr_addr == WA_W'(w)) begin
                    mem_q[w] <= wr_data;
                end
            end
        end
    end

    for (genvar g = 0; g < N_WORDS; g++) begin : g_flat
        assign words_q[g*WORD_W +: WORD_W] = mem_q[g];
    end

endmodule

// File: rtl/syn_expand.sv
module syn_expand
    import syn_pkg::*;
#(
    parameter int MAX_T  = 24,
    parameter int M_MAX  = GF_M_WIDE,
    parameter int WORD_W = 32
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [2:0]                     cfg_t_code,
    input  logic                           cfg_wide,
    input  logic                           wr_en,
    input  logic [$clog2((MAX_T+1)/2)-1:0] wr_addr,
    input  logic [WORD_W-1:0]              wr_data,
    input  logic                           start,
    input  logic [$clog2(2*MAX_T+1)-1:0]   rd_idx,
    output logic                           busy,
    output logic                           done,
    output logic [M_MAX-1:0]               rd_data
);

    localparam int N_WORDS = (MAX_T + 1) / 2;
    localparam int WA_W    = $clog2(N_WORDS);
    localparam int N_SYN   = 2 * MAX_T;
    localparam int IDX_W   = $clog2(N_SYN + 1);
    localparam int K_W     = $clog2(MAX_T);
    localparam int T_W     = $clog2(MAX_T + 1);
    localparam int J_W     = $clog2(M_MAX);
    localparam int PART_W  = WORD_W / 2;
    localparam int BI_W    = $clog2(N_WORDS * WORD_W);
    localparam logic [M_MAX-1:0] GF_ONE   = M_MAX'(1);
    localparam logic [M_MAX-1:0] GF_ALPHA = M_MAX'(2);
    localparam logic [M_MAX-1:0] GF_A2    = M_MAX'(4);

    syn_state_e st_q, st_d;

    logic [T_W-1:0]   run_t_q;
    logic             run_wide_q;
    logic [K_W-1:0]   k_q;
    logic [J_W-1:0]   j_q;
    logic [T_W-1:0]   e_q;
    logic [M_MAX-1:0] pow_q, ai_q;
    logic [M_MAX-1:0] pow_nx, ai_nx, sq_in, sq_out;
    logic [M_MAX-1:0] syn_q [0:N_SYN];

    logic [N_WORDS*WORD_W-1:0] words_q;
    logic [BI_W-1:0]  bit_idx;
    logic             part_bit;
    logic [J_W-1:0]   m_last;
    logic             last_j, last_k, last_e;
    logic [IDX_W-1:0] odd_i, even_i;
    logic             in_odd;

    // Partial-value storage; locked while a job runs.
    syn_part_store #(
        .N_WORDS (N_WORDS),
        .WORD_W  (WORD_W),
        .WA_W    (WA_W)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .lock    (busy),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .words_q (words_q)
    );

    // Next power alpha^(i*(j+1)) from alpha^(i*j).
    syn_gf_mul #(.M_MAX(M_MAX)) u_mul_pow (
        .a (pow_q), .b (ai_q), .wide (run_wide_q), .p (pow_nx)
    );

    // Step alpha^i to alpha^(i+2) for the next odd syndrome.
    syn_gf_mul #(.M_MAX(M_MAX)) u_mul_step (
        .a (ai_q), .b (GF_A2), .wide (run_wide_q), .p (ai_nx)
    );

    // Squarer used for the even syndromes.
    syn_gf_mul #(.M_MAX(M_MAX)) u_mul_sq (
        .a (sq_in), .b (sq_in), .wide (run_wide_q), .p (sq_out)
    );

    // Datapath decode.
    always_comb begin
        bit_idx  = BI_W'(k_q) * BI_W'(PART_W) + BI_W'(j_q);
        part_bit = words_q[bit_idx];
        m_last   = run_wide_q ? J_W'(M_MAX - 1) : J_W'(M_MAX - 2);
        last_j   = (j_q == m_last);
        last_k   = ((T_W'(k_q) + T_W'(1)) == run_t_q);
        last_e   = (e_q == run_t_q);
        odd_i    = IDX_W'({k_q, 1'b1});
        even_i   = IDX_W'({e_q, 1'b0});
        sq_in    = syn_q[e_q];
        in_odd   = (st_q == ST_ODD);
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // Transitions.
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:   if (start) st_d = ST_CLEAR;
            ST_CLEAR:  st_d = ST_ODD;
            ST_ODD:    if (last_j && last_k) st_d = ST_EVEN;
            ST_EVEN:   if (last_e) st_d = ST_FINISH;
            ST_FINISH: st_d = ST_IDLE;
            default:   st_d = ST_IDLE;
        endcase
    end

    // Outputs.
    always_comb begin
        busy = 1'b0;
        done = 1'b0;
        unique case (st_q)
            ST_CLEAR, ST_ODD, ST_EVEN: busy = 1'b1;
            ST_FINISH:                 done = 1'b1;
            default: ;
        endcase
    end

    // Counters, field registers and syndrome storage.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_t_q    <= T_W'(2);
            run_wide_q <= 1'b0;
            k_q        <= '0;
            j_q        <= '0;
            e_q        <= '0;
            pow_q      <= GF_ONE;
            ai_q       <= GF_ALPHA;
            for (int i = 0; i <= N_SYN; i++) begin
                syn_q[i] <= '0;
            end
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    if (start) begin
                        run_t_q    <= T_W'(t_of_code(cfg_t_code));
                        run_wide_q <= cfg_wide;
                    end
                end
                ST_CLEAR: begin
                    for (int i = 0; i <= N_SYN; i++) begin
                        syn_q[i] <= '0;
                    end
                    k_q   <= '0;
                    j_q   <= '0;
                    e_q   <= T_W'(1);
                    pow_q <= GF_ONE;
                    ai_q  <= GF_ALPHA;
                end
                ST_ODD: begin
                    if (part_bit) begin
                        syn_q[odd_i] <= syn_q[odd_i] ^ pow_q;
                    end
                    if (last_j) begin
                        j_q   <= '0;
                        k_q   <= k_q + K_W'(1);
                        pow_q <= GF_ONE;
                        ai_q  <= ai_nx;
                    end else begin
                        j_q   <= j_q + J_W'(1);
                        pow_q <= pow_nx;
                    end
                end
                ST_EVEN: begin
                    syn_q[even_i] <= sq_out;
                    e_q           <= e_q + T_W'(1);
                end
                default: ;
            endcase
        end
    end

    // Read port.
    always_comb begin
        if (int'(rd_idx) <= N_SYN) begin
            rd_data = syn_q[rd_idx];
        end else begin
            rd_data = '0;
        end
    end

endmodule

// File: rtl/syn_expand_chk.sv
module syn_expand_chk #(
    parameter int T_W     = 5,
    parameter int J_W     = 4,
    parameter int WORDS_W = 384
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start,
    input logic               busy,
    input logic               done,
    input logic [T_W-1:0]     run_t,
    input logic               run_wide,
    input logic [J_W-1:0]     j_cnt,
    input logic               in_odd,
    input logic [WORDS_W-1:0] words
);

    logic [11:0] busy_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_cnt <= '0;
        end else if (!busy) begin
            busy_cnt <= '0;
        end else begin
            busy_cnt <= busy_cnt + 12'd1;
        end
    end

    assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (int'(busy_cnt) == int'(run_t) * (run_wide ? 14 : 13) + int'(run_t) + 1));

    assert_busy_from_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    assert_store_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(words));

    assert_bit_in_field_R4: assert property (@(posedge clk) disable iff (!rst_n)
        in_odd |-> (int'(j_cnt) < (run_wide ? 14 : 13)));

    assert_t_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (run_t == T_W'(2) || run_t == T_W'(4) || run_t == T_W'(8) ||
                  run_t == T_W'(12) || run_t == T_W'(24)));

endmodule

bind syn_expand syn_expand_chk #(
    .T_W     (T_W),
    .J_W     (J_W),
    .WORDS_W (N_WORDS * WORD_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .run_t    (run_t_q),
    .run_wide (run_wide_q),
    .j_cnt    (j_q),
    .in_odd   (in_odd),
    .words    (words_q)
);

// File: tb/syn_expand_tb.sv
`timescale 1ns/1ps
module syn_expand_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  cfg_t_code = '0;
    logic        cfg_wide = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        start = 1'b0;
    logic [5:0]  rd_idx = '0;
    logic        busy, done;
    logic [13:0] rd_data;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;
    logic [15:0] exp_part [0:23];

    always #2 clk = ~clk;

    syn_expand u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_t_code(cfg_t_code), .cfg_wide(cfg_wide),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .start(start),
        .rd_idx(rd_idx), .busy(busy), .done(done), .rd_data(rd_data)
    );

    // {t code, wide, base, step}; partial k = (base + k*step) masked to m bits
    localparam logic [35:0] VECS [0:5] = '{
        {3'd0, 1'b0, 16'h0001, 16'h0000},
        {3'd1, 1'b0, 16'h0002, 16'h0000},
        {3'd2, 1'b1, 16'h1A5F, 16'h0313},
        {3'd3, 1'b0, 16'h1FFF, 16'h0101},
        {3'd4, 1'b1, 16'h3FFF, 16'h2345},
        {3'd4, 1'b0, 16'h0000, 16'h0000}
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    function automatic int tdec(input logic [2:0] c);
        case (c)
            3'd1: return 4;
            3'd2: return 8;
            3'd3: return 12;
            3'd4: return 24;
            default: return 2;
        endcase
    endfunction

    function automatic logic [13:0] mulx(input logic [13:0] v, input logic w);
        logic [14:0] s;
        s = {v, 1'b0};
        if (w) begin
            if (s[14]) s = s ^ 15'h4443;
        end else begin
            if (s[13]) s = s ^ 15'h201B;
        end
        return s[13:0];
    endfunction

    // Least-significant-bit-first product.
    function automatic logic [13:0] gmul(input logic [13:0] a, input logic [13:0] b, input logic w);
        logic [13:0] r;
        logic [13:0] x;
        r = '0;
        x = a;
        for (int i = 0; i < 14; i++) begin
            if (b[i]) r = r ^ x;
            x = mulx(x, w);
        end
        return r;
    endfunction

    // Received word p evaluated at alpha^e.
    function automatic logic [13:0] eval_at(input logic [15:0] p, input int e, input logic w);
        logic [13:0] base;
        logic [13:0] acc;
        logic [13:0] pw;
        int m;
        m = w ? 14 : 13;
        base = 14'd1;
        for (int i = 0; i < e; i++) base = mulx(base, w);
        acc = '0;
        pw = 14'd1;
        for (int j = 0; j < m; j++) begin
            if (p[j]) acc = acc ^ pw;
            pw = gmul(pw, base, w);
        end
        return acc;
    endfunction

    function automatic logic [13:0] exp_syn(input int e, input logic w);
        int o;
        o = e;
        while ((o % 2) == 0) o = o / 2;
        return eval_at(exp_part[(o - 1) / 2], e, w);
    endfunction

    task automatic load_parts(input logic w, input logic [15:0] base, input logic [15:0] step);
        logic [15:0] mask;
        logic [15:0] v;
        mask = w ? 16'h3FFF : 16'h1FFF;
        for (int k = 0; k < 24; k++) begin
            v = base + 16'(k) * step;
            exp_part[k] = v & mask;
        end
        for (int a = 0; a < 12; a++) begin
            @(negedge clk);
            wr_en = 1'b1;
            wr_addr = 4'(a);
            // R4: bits at positions m and above carry junk
            wr_data = {exp_part[2*a+1] | ~mask, exp_part[2*a] | ~mask};
        end
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic check_syn(input int t, input logic w, input string tag);
        logic [13:0] e_v;
        for (int e = 0; e < 64; e++) begin
            rd_idx = 6'(e);
            #0.1;
            if (e >= 1 && e <= 2 * t) e_v = exp_syn(e, w);
            else e_v = '0;
            chk(rd_data == e_v,
                $sformatf("R2 R3 R5 R6 %s idx %0d", tag, e), 32'(rd_data), 32'(e_v));
        end
    endtask

    task automatic do_run(input logic [2:0] tc, input logic w, input bit noise,
                          input bit co_wr, input logic [31:0] co_data, input string tag);
        int n;
        int t;
        int m;
        t = tdec(tc);
        m = w ? 14 : 13;
        @(negedge clk);
        cfg_t_code = tc;
        cfg_wide = w;
        start = 1'b1;
        if (co_wr) begin
            wr_en = 1'b1;
            wr_addr = 4'd0;
            wr_data = co_data;
        end
        @(posedge clk);
        #1;
        n = 1;
        start = 1'b0;
        wr_en = 1'b0;
        chk(busy == 1'b1, {"R7 busy after start ", tag}, 32'(busy), 32'd1);
        while (!done && n < 3000) begin
            if (noise && n == 3) begin
                start = 1'b1;
                wr_en = 1'b1;
                wr_addr = 4'd0;
                wr_data = '1;
            end else if (noise && n == 4) begin
                start = 1'b0;
                wr_en = 1'b0;
            end
            @(posedge clk);
            #1;
            n++;
        end
        chk(n == t * m + t + 2, {"R7 R9 latency ", tag}, 32'(n), 32'(t * m + t + 2));
        chk(busy == 1'b0, {"R7 busy low at done ", tag}, 32'(busy), 32'd0);
        @(posedge clk);
        #1;
        chk(done == 1'b0, {"R7 done one cycle ", tag}, 32'(done), 32'd0);
        check_syn(t, w, tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R10: reset state
        chk(busy == 1'b0, "R10 busy in reset", 32'(busy), 32'd0);
        chk(done == 1'b0, "R10 done in reset", 32'(done), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        for (int e = 1; e <= 48; e += 47) begin
            rd_idx = 6'(e);
            #0.1;
            chk(rd_data == 14'd0, "R10 syndrome after reset", 32'(rd_data), 32'd0);
        end

        // Table walk: R1 R2 R3 R4 R5 R6 R7
        for (int v = 0; v < 6; v++) begin
            load_parts(VECS[v][32], VECS[v][31:16], VECS[v][15:0]);
            do_run(VECS[v][35:33], VECS[v][32], 1'b0, 1'b0, 32'd0, $sformatf("vec%0d", v));
        end

        // R1: unknown code 7 acts as t=2; R6: leftovers from t=24 are cleared
        load_parts(1'b1, 16'h2C71, 16'h0777);
        do_run(3'd4, 1'b1, 1'b0, 1'b0, 32'd0, "pre_t24");
        do_run(3'd7, 1'b1, 1'b0, 1'b0, 32'd0, "code7");

        // R8 R9: write and start pulse mid-run are ignored
        load_parts(1'b0, 16'h0ABC, 16'h0123);
        do_run(3'd2, 1'b0, 1'b1, 1'b0, 32'd0, "busy_noise");

        // R8: write on the start edge is used
        exp_part[0] = 16'h1234;
        exp_part[1] = 16'h0F0F;
        do_run(3'd0, 1'b0, 1'b0, 1'b1, {16'h0F0F, 16'h1234}, "co_write");

        // R5: all-zero partials with wide field
        load_parts(1'b1, 16'h0000, 16'h0000);
        do_run(3'd3, 1'b1, 1'b0, 1'b0, 32'd0, "zero_wide");

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule